// File: doc/BRIEF.md
# Paged Address Translator with Usage Tracking

This block sits between a CPU and its main memory and turns logical addresses in the low mapped region into physical addresses. The region is cut into 4 KB pages. Each page has a 16-bit entry in an on-block map RAM, indexed by logical address bits 21:12. The entry supplies a 10-bit physical page number, which is joined to the 12-bit page offset to form the physical address. Addresses at or above the top of the mapped region (0x400000 with the default parameters) are passed through unchanged.

Each entry also holds a two-bit usage field and a write-enable flag. Every access to the mapped region moves the usage field forward. A page that has never been used becomes read-touched on a read and dirty on a write. A read-touched page becomes dirty on a write. An absent page is left alone and flagged as not present. The write-enable flag and all other entry bits are never touched by these updates.

A byte-wide host port reads and writes map entries so that software can build and inspect the map. The translation result is registered and appears one cycle after the access strobe. A usage update is a single-cycle read-modify-write. When the host port writes in the same cycle, the host write takes the RAM's write port.

Top module: `pgx_translator`

## Requirements
- R1: During and after reset, xl_valid, xl_absent, xl_phys and host_rdata are zero, and every map entry reads back as 0x0000 (page absent).
- R2: xl_valid is high in exactly the cycle after a cycle with acc_valid high. xl_phys and xl_absent belong to that access.
- R3: For an address below 0x400000, xl_phys equals entry bits 9:0 followed by address bits 11:0, zero-extended to 24 bits. The entry is selected by address bits 21:12.
- R4: For an address at or above 0x400000, xl_phys equals the address, xl_absent is low, and no map entry changes.
- R5: A usage update changes only entry bits 14:13. Bit 15 (write enable), bits 12:10 and bits 9:0 keep their values.
- R6: An access to a page whose entry bits 14:13 are 1 (fresh) sets them to 3 on a write and to 2 on a read.
- R7: A write to a page with bits 14:13 equal to 2 or 3 sets them to 3. A read leaves them unchanged.
- R8: An access to a page with bits 14:13 equal to 0 raises xl_absent and leaves the entry unchanged.
- R9: The host port is big-endian and byte-addressed. Byte address 2i holds bits 15:8 of entry i, and byte address 2i+1 holds bits 7:0. Read data appears on host_rdata one cycle after the request.
- R10: When a host write and an access fall in the same cycle, the host byte is stored and that access's usage update is dropped. The translation still uses the entry as it stood before that cycle.
- R11: An access in the cycle right after another access sees the usage update made by the earlier one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Access strobe, one cycle per access |
| acc_write | input | 1 | 1 = write access, 0 = read access |
| acc_addr | input | 24 | Logical byte address |
| host_en | input | 1 | Host map-port request |
| host_we | input | 1 | 1 = host byte write, 0 = host byte read |
| host_addr | input | 11 | Host byte address into the map RAM |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, registered |
| xl_valid | output | 1 | Translation result valid |
| xl_phys | output | 24 | Physical (or passed-through) address |
| xl_absent | output | 1 | Accessed page is not present |

## Verification
An access's usage update and a host write compete for the one write port of the map RAM in the same cycle. The bench drives both in one cycle in two cases: the host write hits the entry being accessed, and the host write hits a different entry. It then judges xl_phys against the entry as it stood before that cycle. It reads both entries back through the host port and expects the host byte to be present and the usage field of the accessed entry to be unchanged. Back-to-back accesses to one page check that the second access observes the first one's update.

// File: rtl/pgx_pkg.sv
// Package: shared constants and the usage-state type for the paged translator.
// Assumes a 16-bit map entry with a 10-bit physical page number.
package pgx_pkg;

    localparam int ENTRY_W = 16;   // map entry width
    localparam int PPN_W   = 10;   // physical page number width (entry bits 9:0)
    localparam int ST_LO   = 13;   // usage field low bit
    localparam int ST_HI   = 14;   // usage field high bit
    localparam int WEN_BIT = 15;   // write-enable flag

    typedef enum logic [1:0] {
        PG_ABSENT = 2'd0,
        PG_FRESH  = 2'd1,
        PG_READ   = 2'd2,
        PG_DIRTY  = 2'd3
    } pg_state_e;

endpackage

// File: rtl/pgx_map_store.sv
// Module: map entry storage.
// Holds 2**PAGE_W entries with two combinational read ports (access side,
// host side) and one synchronous write port. Reset clears every entry,
// so every page starts out absent.
module pgx_map_store
    import pgx_pkg::*;
#(
    parameter int PAGE_W = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PAGE_W-1:0]  rd_idx_a,
    output logic [ENTRY_W-1:0] rd_data_a,
    input  logic [PAGE_W-1:0]  rd_idx_b,
    output logic [ENTRY_W-1:0] rd_data_b,
    input  logic               wr_en,
    input  logic [PAGE_W-1:0]  wr_idx,
    input  logic [ENTRY_W-1:0] wr_data
);

    localparam int DEPTH = 1 << PAGE_W;

    logic [ENTRY_W-1:0] entries [DEPTH];

    // Purpose: clear on reset, otherwise apply the single write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                entries[i] <= '0;
            end
        end else if (wr_en) begin
            entries[wr_idx] <= wr_data;
        end
    end

    // Purpose: combinational read for the access path.
    assign rd_data_a = entries[rd_idx_a];
    // Purpose: combinational read for the host path.
    assign rd_data_b = entries[rd_idx_b];

endmodule

// File: rtl/pgx_usage_update.sv
// Module: usage-state step for one access.
// Computes the entry value after an access and whether it must be written.
// Only the usage field may differ from the current entry.
// Assumes the caller qualifies the request with the write-port arbitration.
module pgx_usage_update
    import pgx_pkg::*;
(
    input  logic               acc_valid,
    input  logic               acc_write,
    input  logic               in_region,
    input  logic [ENTRY_W-1:0] cur_entry,
    output logic               upd_req,
    output logic [ENTRY_W-1:0] upd_entry,
    output logic               absent
);

    pg_state_e cur_st;
    pg_state_e nxt_st;

    // Purpose: decode the usage field and pick the state after this access.
    always_comb begin
        cur_st = pg_state_e'(cur_entry[ST_HI:ST_LO]);
        unique case (cur_st)
            PG_ABSENT: nxt_st = PG_ABSENT;
            PG_FRESH:  nxt_st = acc_write ? PG_DIRTY : PG_READ;
            PG_READ:   nxt_st = acc_write ? PG_DIRTY : PG_READ;
            PG_DIRTY:  nxt_st = PG_DIRTY;
            default:   nxt_st = cur_st;
        endcase
        upd_entry              = cur_entry;
        upd_entry[ST_HI:ST_LO] = nxt_st;
    end

    // Purpose: flag absent pages and request a write only when the state moves.
    assign absent  = (cur_st == PG_ABSENT);
    assign upd_req = acc_valid & in_region & ~absent & (nxt_st != cur_st);

endmodule

// File: rtl/pgx_host_lane.sv
// Module: host byte port onto the map RAM.
// Big-endian: an even byte address selects entry bits 15:8 and an odd one
// selects bits 7:0. A write merges the byte into the current entry. A read
// returns the selected byte one cycle later and holds it until the next read.
module pgx_host_lane
    import pgx_pkg::*;
#(
    parameter int PAGE_W = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_en,
    input  logic               host_we,
    input  logic [PAGE_W:0]    host_addr,
    input  logic [7:0]         host_wdata,
    input  logic [ENTRY_W-1:0] cur_entry,
    output logic [PAGE_W-1:0]  host_idx,
    output logic               host_wr,
    output logic [ENTRY_W-1:0] host_merged,
    output logic [7:0]         host_rdata
);

    logic lane_low;

    assign host_idx = host_addr[PAGE_W:1];
    assign lane_low = host_addr[0];
    assign host_wr  = host_en & host_we;

    // Purpose: merge the written byte into the selected lane.
    always_comb begin
        host_merged = cur_entry;
        if (lane_low) host_merged[7:0]  = host_wdata;
        else          host_merged[15:8] = host_wdata;
    end

    // Purpose: register the read byte for the host.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_rdata <= '0;
        end else if (host_en && !host_we) begin
            host_rdata <= lane_low ? cur_entry[7:0] : cur_entry[15:8];
        end
    end

endmodule

// File: rtl/pgx_translator.sv
// Module: paged address translator with per-page usage tracking (top).
// Translates addresses below 2**(PAGE_W+OFS_W) through the map RAM and passes
// higher addresses through. Each access updates the page's usage field.
// Assumes: at most one access per cycle, and the host port takes the write
// port whenever it writes. The result is registered (one cycle latency).
module pgx_translator
    import pgx_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int PAGE_W = 10,
    parameter int OFS_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              host_en,
    input  logic              host_we,
    input  logic [PAGE_W:0]   host_addr,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    output logic              xl_valid,
    output logic [ADDR_W-1:0] xl_phys,
    output logic              xl_absent
);

    localparam int REG_W = PAGE_W + OFS_W;   // width of the mapped region

    logic               in_region;
    logic [PAGE_W-1:0]  acc_idx;
    logic [ENTRY_W-1:0] acc_entry;
    logic [ENTRY_W-1:0] host_entry;
    logic [PAGE_W-1:0]  host_idx;
    logic               host_wr;
    logic [ENTRY_W-1:0] host_merged;
    logic               upd_req;
    logic               upd_commit;
    logic [ENTRY_W-1:0] upd_entry;
    logic               absent;
    logic               wr_en;
    logic [PAGE_W-1:0]  wr_idx;
    logic [ENTRY_W-1:0] wr_data;

    // Purpose: decide whether the address falls inside the mapped region.
    generate
        if (ADDR_W > REG_W) begin : g_region_cmp
            assign in_region = ~|acc_addr[ADDR_W-1:REG_W];
        end else begin : g_region_all
            assign in_region = 1'b1;
        end
    endgenerate

    assign acc_idx = acc_addr[REG_W-1:OFS_W];

    pgx_map_store #(.PAGE_W(PAGE_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx_a  (acc_idx),
        .rd_data_a (acc_entry),
        .rd_idx_b  (host_idx),
        .rd_data_b (host_entry),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data)
    );

    pgx_usage_update u_usage (
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .in_region (in_region),
        .cur_entry (acc_entry),
        .upd_req   (upd_req),
        .upd_entry (upd_entry),
        .absent    (absent)
    );

    pgx_host_lane #(.PAGE_W(PAGE_W)) u_host (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_en     (host_en),
        .host_we     (host_we),
        .host_addr   (host_addr),
        .host_wdata  (host_wdata),
        .cur_entry   (host_entry),
        .host_idx    (host_idx),
        .host_wr     (host_wr),
        .host_merged (host_merged),
        .host_rdata  (host_rdata)
    );

    // Purpose: arbitrate the single write port, with the host taking priority.
    assign upd_commit = upd_req & ~host_wr;
    assign wr_en      = host_wr | upd_req;
    assign wr_idx     = host_wr ? host_idx    : acc_idx;
    assign wr_data    = host_wr ? host_merged : upd_entry;

    // Purpose: register the translation result one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xl_valid  <= 1'b0;
            xl_phys   <= '0;
            xl_absent <= 1'b0;
        end else begin
            xl_valid  <= acc_valid;
            xl_absent <= acc_valid & in_region & absent;
            if (acc_valid) begin
                xl_phys <= in_region
                         ? ADDR_W'({acc_entry[PPN_W-1:0], acc_addr[OFS_W-1:0]})
                         : acc_addr;
            end
        end
    end

    // R5: a committed update keeps every bit outside the usage field.
    a_r5_keep_other_bits: assert property (@(posedge clk) disable iff (!rst_n)
        upd_commit |-> (upd_entry[WEN_BIT] == acc_entry[WEN_BIT])
                       && (upd_entry[ST_LO-1:0] == acc_entry[ST_LO-1:0]));

    // R7: the usage field only moves forward, never from absent.
    a_r7_forward_only: assert property (@(posedge clk) disable iff (!rst_n)
        upd_commit |-> (upd_entry[ST_HI:ST_LO] > acc_entry[ST_HI:ST_LO])
                       && (acc_entry[ST_HI:ST_LO] != 2'd0));

    // R8: an absent page is never written by an access.
    a_r8_absent_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && in_region && acc_entry[ST_HI:ST_LO] == 2'd0) |-> !upd_req);

    // R4: a pass-through access never requests a map write.
    a_r4_passthru_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !in_region) |-> !upd_req);

    // R2: the result follows the strobe by exactly one cycle.
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> xl_valid);
    a_r2_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !xl_valid);

    // R8: the absent flag only accompanies a valid result.
    a_r8_absent_valid: assert property (@(posedge clk) disable iff (!rst_n)
        xl_absent |-> xl_valid);

endmodule

// File: tb/pgx_translator_bench.sv
// Bench: sweeps every page in both access directions and covers host-port
// collisions and pass-through addresses. Expectations come from an entry
// model computed from the requirements.
module pgx_translator_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [23:0] acc_addr = '0;
    logic        host_en = 1'b0;
    logic        host_we = 1'b0;
    logic [10:0] host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        xl_valid;
    logic [23:0] xl_phys;
    logic        xl_absent;

    int checks = 0;
    int errs = 0;
    bit finished = 0;
    logic [15:0] model [1024];

    always #5 clk = ~clk;

    pgx_translator u_pgx_translator (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .host_en(host_en), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .xl_valid(xl_valid), .xl_phys(xl_phys), .xl_absent(xl_absent)
    );

    task automatic chk(input string tag, input logic [31:0] act,
                       input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [15:0] step_entry(input logic [15:0] e, input logic w);
        logic [15:0] r;
        r = e;
        case (e[14:13])
            2'd1: r[14:13] = w ? 2'd3 : 2'd2;
            2'd2: r[14:13] = w ? 2'd3 : 2'd2;
            default: r = e;
        endcase
        return r;
    endfunction

    function automatic string tag_of(input logic [1:0] st);
        if (st == 2'd0) return "R8";
        if (st == 2'd1) return "R6";
        return "R7";
    endfunction

    // R9: host byte write, big-endian lanes.
    task automatic host_wb(input logic [10:0] ba, input logic [7:0] d);
        host_en = 1'b1; host_we = 1'b1; host_addr = ba; host_wdata = d;
        @(negedge clk);
        host_en = 1'b0; host_we = 1'b0;
        if (ba[0]) model[ba[10:1]][7:0] = d;
        else       model[ba[10:1]][15:8] = d;
    endtask

    task automatic set_entry(input int idx, input logic [15:0] v);
        host_wb({idx[9:0], 1'b0}, v[15:8]);
        host_wb({idx[9:0], 1'b1}, v[7:0]);
    endtask

    // R9: host read of both bytes of an entry, compared against the model.
    task automatic rd_entry(input int idx, input string tag);
        host_en = 1'b1; host_we = 1'b0; host_addr = {idx[9:0], 1'b0};
        @(negedge clk);
        chk(tag, 32'(host_rdata), 32'(model[idx][15:8]), $sformatf("entry %0d high byte", idx));
        host_addr = {idx[9:0], 1'b1};
        @(negedge clk);
        chk(tag, 32'(host_rdata), 32'(model[idx][7:0]), $sformatf("entry %0d low byte", idx));
        host_en = 1'b0;
    endtask

    // One access; result checked after the registering edge.
    task automatic do_access(input logic [23:0] a, input logic w, input string tag);
        logic [23:0] exp_p;
        logic        exp_abs;
        logic        in_r;
        int          idx;
        in_r = (a < 24'h400000);
        idx  = int'(a[21:12]);
        if (in_r) begin
            exp_p   = {2'b00, model[idx][9:0], a[11:0]};
            exp_abs = (model[idx][14:13] == 2'd0);
        end else begin
            exp_p   = a;
            exp_abs = 1'b0;
        end
        acc_valid = 1'b1; acc_write = w; acc_addr = a;
        @(negedge clk);
        acc_valid = 1'b0;
        chk("R2", 32'(xl_valid), 32'd1, "valid after strobe");
        chk(tag, 32'(xl_phys), 32'(exp_p), $sformatf("phys for %0h", a));
        chk(tag, 32'(xl_absent), 32'(exp_abs), $sformatf("absent for %0h", a));
        if (in_r) model[idx] = step_entry(model[idx], w);
    endtask

    initial begin
        #1ms;
        if (!finished) begin
            errs++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 1024; i++) model[i] = 16'h0000;
        repeat (3) @(negedge clk);
        // R1: outputs held at zero while in reset.
        chk("R1", 32'(xl_valid), 0, "valid in reset");
        chk("R1", 32'(xl_phys), 0, "phys in reset");
        chk("R1", 32'(xl_absent), 0, "absent in reset");
        chk("R1", 32'(host_rdata), 0, "rdata in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", 32'(xl_valid), 0, "valid after reset");
        // R1: every entry cleared.
        for (int i = 0; i < 1024; i++) rd_entry(i, "R1");

        // R9: fill every entry through the host port.
        for (int i = 0; i < 1024; i++) begin
            logic [15:0] v;
            v = {i[2], 2'(i % 4), i[5:3], 10'((i * 37 + 5) & 1023)};
            set_entry(i, v);
        end
        for (int i = 0; i < 1024; i += 61) rd_entry(i, "R9");

        // R3, R5, R6, R7, R8: two sweeps over all pages with mixed directions.
        for (int pass = 0; pass < 2; pass++) begin
            for (int i = 0; i < 1024; i++) begin
                logic        w;
                logic [23:0] a;
                string       t;
                w = i[3] ^ i[0] ^ pass[0];
                a = {2'b00, i[9:0], 12'((i * 13 + 7) & 12'hFFF)};
                t = tag_of(model[i][14:13]);
                do_access(a, w, {"R3 ", t});
                rd_entry(i, {"R5 ", t});
            end
        end

        // R3: last translated address.
        set_entry(1023, 16'h27FF);
        do_access(24'h3FFFFF, 1'b0, "R3");

        // R4: pass-through addresses leave the aliasing entries alone.
        do_access(24'h400000, 1'b1, "R4");
        do_access(24'hFFFFFF, 1'b1, "R4");
        do_access(24'h7ABCDE, 1'b0, "R4");
        rd_entry(0, "R4");
        rd_entry(1023, "R4");
        rd_entry(16'h3AB, "R4");

        // R11: back-to-back read then write on one fresh page.
        set_entry(5, 16'h2155);
        do_access(24'h005010, 1'b0, "R11");
        do_access(24'h005020, 1'b1, "R11");
        rd_entry(5, "R11");
        chk("R11", 32'(model[5]), 32'h6155, "model after read then write");
        // R11: back-to-back reads settle on read-touched.
        set_entry(6, 16'h2066);
        do_access(24'h006000, 1'b0, "R11");
        do_access(24'h006FFF, 1'b0, "R11");
        rd_entry(6, "R11");
        // R2: valid drops when no strobe.
        @(negedge clk);
        chk("R2", 32'(xl_valid), 0, "valid without strobe");

        // R10: host write to the same entry in the access cycle.
        set_entry(7, 16'h2077);
        host_en = 1'b1; host_we = 1'b1; host_addr = {10'd7, 1'b0}; host_wdata = 8'h80;
        acc_valid = 1'b1; acc_write = 1'b1; acc_addr = 24'h007ABC;
        @(negedge clk);
        host_en = 1'b0; host_we = 1'b0; acc_valid = 1'b0;
        chk("R10", 32'(xl_phys), 32'h077ABC, "phys uses old entry");
        chk("R10", 32'(xl_absent), 0, "absent uses old entry");
        model[7] = 16'h8077;
        rd_entry(7, "R10");
        // R10: host write to a different entry drops the access update.
        set_entry(9, 16'h2199);
        host_en = 1'b1; host_we = 1'b1; host_addr = {10'd8, 1'b1}; host_wdata = 8'h5A;
        acc_valid = 1'b1; acc_write = 1'b0; acc_addr = 24'h009123;
        @(negedge clk);
        host_en = 1'b0; host_we = 1'b0; acc_valid = 1'b0;
        chk("R10", 32'(xl_phys), 32'h199123, "phys during host write");
        model[8][7:0] = 8'h5A;
        rd_entry(9, "R10");
        rd_entry(8, "R10");

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule